// File: doc/BRIEF.md
# Idle-Delimited Packet Serial Receiver

This block receives asynchronous serial characters (one start bit, eight data bits LSB first, one stop bit) and groups them into packets. A packet ends when the line has been idle for a programmable number of bit times. Received bytes are packed little-endian into 32-bit words and stored in a data FIFO. When a packet closes, a 16-bit count entry is pushed into a separate count FIFO. The entry holds the byte count and per-packet error flags.

Software programs a 20-bit phase increment equal to rate × 2^20 / f_clk. It sets the gap length, the receive enable and the half-duplex input mask through a mode register, and polls the same register for status. The status gives the number of waiting packets, whether the data FIFO holds data, whether a packet is in progress, the mask state, and sticky error bits. To drain one packet, software reads a count entry, which pops it, and then reads ceil(n/4) data words.

Top module: `pkt_uart_rx`

## Requirements
- R1: While mode bit 3 is clear, no character is captured: no packet is ever counted and the data FIFO stays empty.
- R2: A packet closes once the line has stayed idle for the number of bit times in mode bits 15..8; characters separated by a shorter gap belong to the same packet.
- R3: Each count entry carries the packet byte count in bits 9..0. Asserting `cnt_re_i` pops the entry shown on `cnt_o`.
- R4: Status bits 20..16 give the number of packets waiting in the count FIFO, and bit 21 is set while the data FIFO is not empty. After reset, `mode_o` reads zero.
- R5: Status bit 7 is set from the first character of a packet until that packet closes.
- R6: A missing stop bit drops that character, sets bit 15 of the packet's count entry, and sets sticky status bit 1.
- R7: A start bit that is no longer low at mid-bit sets sticky status bit 0 and returns the receiver to idle; outside a packet it creates no packet.
- R8: Bytes are packed little-endian, the first byte in bits 7..0, so an n-byte packet occupies ceil(n/4) words with zeroed unused upper lanes.
- R9: Writing 0x80010000 to the mode register aborts reception, flushes both FIFOs and clears the sticky bits, leaving mode bits 15..8, 3 and 2 unchanged.
- R10: With mode bit 2 set, the input is forced idle while `tx_busy_i` is high, and status bit 6 shows the mask is active.
- R11: Popping the count FIFO while empty, or overflowing either FIFO, sets sticky status bit 4.
- R12: One bit time equals 2^20 / increment clock cycles, so the same byte stream decodes correctly at each programmed rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rxd_i | input | 1 | Serial receive line, idle high |
| tx_busy_i | input | 1 | Local transmitter is driving the shared line |
| rate_we_i | input | 1 | Write strobe for the bit-rate increment |
| rate_i | input | 20 | Bit-rate phase increment |
| mode_we_i | input | 1 | Write strobe for the mode register |
| mode_i | input | 32 | Mode write data or clear command |
| mode_o | output | 32 | Mode and status readback |
| cnt_re_i | input | 1 | Pop the head count entry |
| cnt_o | output | 16 | Head count entry: flags in bits 15 and 14, byte count in bits 9..0 |
| data_re_i | input | 1 | Pop the head data word |
| data_o | output | 32 | Head data word |

## Verification
The hardest case to reach is a packet whose count entry carries the overrun flag and still holds valid data. To reach it, the stimulus drives a character with a low stop bit and releases the line less than the idle gap later. It then sends a good character, so the bad character and the good one fall into the same packet. A second hard case is a short glitch on the line that must raise the false-start bit without creating an empty packet. The bench produces it with a four-cycle low pulse, shorter than half a bit time, after all packets have been drained.

// File: rtl/pkt_uart_rx_pkg.sv
package pkt_uart_rx_pkg;
  localparam logic [31:0] CLR_CMD = 32'h8001_0000;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_STOP, ST_BRK
  } rx_state_e;

  typedef struct packed {
    logic       ovr;
    logic       fs;
    logic [3:0] rsvd;
    logic [9:0] bytes;
  } cnt_word_t;
endpackage

// File: rtl/pkt_uart_fifo.sv
module pkt_uart_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          pop_i,
  output logic [W-1:0]  rdata_o,
  output logic          full_o,
  output logic [LW-1:0] level_o
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [LW-1:0] lvl_q;
  logic          do_push, do_pop;

  assign full_o  = lvl_q == LW'(DEPTH);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && (lvl_q != '0);
  assign rdata_o = mem[rp_q];
  assign level_o = lvl_q;

  always_ff @(posedge clk_i) if (do_push && !clr_i) mem[wp_q] <= wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0; rp_q <= '0; lvl_q <= '0;
    end else if (clr_i) begin
      wp_q <= '0; rp_q <= '0; lvl_q <= '0;
    end else begin
      if (do_push) wp_q <= wp_q + 1'b1;
      if (do_pop)  rp_q <= rp_q + 1'b1;
      lvl_q <= lvl_q + LW'(do_push) - LW'(do_pop);
    end
  end

  // R11
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i && !clr_i) |=> lvl_q == $past(lvl_q));
endmodule

// File: rtl/pkt_uart_rx_char.sv
module pkt_uart_rx_char
  import pkt_uart_rx_pkg::*;
#(
  parameter int RATE_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic              rxd_i,
  input  logic [RATE_W-1:0] incr_i,
  output logic              tick_o,
  output logic              busy_o,
  output logic              byte_vld_o,
  output logic [7:0]        byte_o,
  output logic              fs_err_o,
  output logic              ovr_err_o
);
  localparam logic [RATE_W-1:0] HALF = RATE_W'(1) << (RATE_W - 1);

  rx_state_e         st_q;
  logic [1:0]        sync_q;
  logic              rxd_s;
  logic [RATE_W-1:0] acc_q;
  logic [RATE_W:0]   sum;
  logic [2:0]        bit_q;
  logic [7:0]        sh_q;

  assign rxd_s  = sync_q[1];
  assign sum    = {1'b0, acc_q} + {1'b0, incr_i};
  assign tick_o = sum[RATE_W];
  assign busy_o = st_q != ST_IDLE;
  assign byte_o = sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; sync_q <= 2'b11; acc_q <= '0; bit_q <= '0; sh_q <= '0;
      byte_vld_o <= 1'b0; fs_err_o <= 1'b0; ovr_err_o <= 1'b0;
    end else begin
      sync_q     <= {sync_q[0], rxd_i};
      byte_vld_o <= 1'b0;
      fs_err_o   <= 1'b0;
      ovr_err_o  <= 1'b0;
      acc_q      <= sum[RATE_W-1:0];
      if (clr_i) begin
        st_q <= ST_IDLE; acc_q <= '0; bit_q <= '0;
      end else begin
        unique case (st_q)
          ST_IDLE: if (en_i && !rxd_s) begin
            acc_q <= HALF;  // first overflow lands mid start bit
            st_q  <= ST_START;
          end
          ST_START: if (tick_o) begin
            if (!rxd_s) begin st_q <= ST_DATA; bit_q <= '0; end
            else begin fs_err_o <= 1'b1; st_q <= ST_IDLE; end
          end
          ST_DATA: if (tick_o) begin
            sh_q  <= {rxd_s, sh_q[7:1]};
            bit_q <= bit_q + 1'b1;
            if (bit_q == 3'd7) st_q <= ST_STOP;
          end
          ST_STOP: if (tick_o) begin
            if (rxd_s) begin byte_vld_o <= 1'b1; st_q <= ST_IDLE; end
            else begin ovr_err_o <= 1'b1; st_q <= ST_BRK; end
          end
          ST_BRK: if (rxd_s) st_q <= ST_IDLE;
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  // R1
  no_start_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && !en_i) |=> st_q == ST_IDLE);
endmodule

// File: rtl/pkt_uart_rx.sv
module pkt_uart_rx
  import pkt_uart_rx_pkg::*;
#(
  parameter int RATE_W      = 20,
  parameter int DATA_DEPTH  = 32,
  parameter int CNT_DEPTH   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rxd_i,
  input  logic              tx_busy_i,
  input  logic              rate_we_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              mode_we_i,
  input  logic [31:0]       mode_i,
  output logic [31:0]       mode_o,
  input  logic              cnt_re_i,
  output logic [15:0]       cnt_o,
  input  logic              data_re_i,
  output logic [31:0]       data_o
);
  localparam int DLW = $clog2(DATA_DEPTH + 1);
  localparam int CLW = $clog2(CNT_DEPTH + 1);

  logic [RATE_W-1:0] rate_q;
  logic [7:0]        gap_lim_q, gap_q;
  logic              en_q, mask_en_q, mask_act, clr;
  logic              tick, busy, byte_vld, fs_err, ovr_err;
  logic [7:0]        rx_byte;
  logic              in_pkt_q, pkt_ovr_q, pkt_fs_q, close;
  logic [9:0]        nbytes_q;
  logic [1:0]        lane_q;
  logic [31:0]       word_q, d_wdata;
  logic              d_push, d_full, c_full, c_empty;
  logic [DLW-1:0]    d_level;
  logic [CLW-1:0]    c_level;
  logic              ovr_stk_q, fs_stk_q, fifo_err_q;
  cnt_word_t         c_wdata;
  logic [4:0]        pkt_cnt;

  assign clr      = mode_we_i && (mode_i == CLR_CMD);
  assign mask_act = mask_en_q && tx_busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rate_q <= '0; gap_lim_q <= '0; en_q <= 1'b0; mask_en_q <= 1'b0;
    end else begin
      if (rate_we_i) rate_q <= rate_i;
      if (mode_we_i && !clr) begin
        gap_lim_q <= mode_i[15:8];
        en_q      <= mode_i[3];
        mask_en_q <= mode_i[2];
      end
    end
  end

  pkt_uart_rx_char #(.RATE_W(RATE_W)) i_char (
    .clk_i, .rst_ni, .clr_i(clr), .en_i(en_q), .rxd_i(rxd_i | mask_act),
    .incr_i(rate_q), .tick_o(tick), .busy_o(busy), .byte_vld_o(byte_vld),
    .byte_o(rx_byte), .fs_err_o(fs_err), .ovr_err_o(ovr_err)
  );

  assign close = in_pkt_q && !busy && tick &&
                 (({1'b0, gap_q} + 9'd1) >= {1'b0, gap_lim_q});

  always_comb begin
    d_push  = 1'b0;
    d_wdata = word_q;
    if (byte_vld && lane_q == 2'd3) begin
      d_push  = 1'b1;
      d_wdata = {rx_byte, word_q[23:0]};
    end else if (close && lane_q != 2'd0) begin
      d_push  = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_pkt_q <= 1'b0; pkt_ovr_q <= 1'b0; pkt_fs_q <= 1'b0; nbytes_q <= '0;
      gap_q <= '0; lane_q <= '0; word_q <= '0;
      ovr_stk_q <= 1'b0; fs_stk_q <= 1'b0; fifo_err_q <= 1'b0;
    end else if (clr) begin
      in_pkt_q <= 1'b0; pkt_ovr_q <= 1'b0; pkt_fs_q <= 1'b0; nbytes_q <= '0;
      gap_q <= '0; lane_q <= '0; word_q <= '0;
      ovr_stk_q <= 1'b0; fs_stk_q <= 1'b0; fifo_err_q <= 1'b0;
    end else begin
      if (byte_vld) begin
        word_q[lane_q*8 +: 8] <= rx_byte;
        if (lane_q == 2'd3) word_q <= '0;
        lane_q   <= lane_q + 1'b1;
        if (nbytes_q != '1) nbytes_q <= nbytes_q + 1'b1;
        in_pkt_q <= 1'b1;
        gap_q    <= '0;
      end
      if (ovr_err) begin
        in_pkt_q <= 1'b1; pkt_ovr_q <= 1'b1; ovr_stk_q <= 1'b1; gap_q <= '0;
      end
      if (fs_err) begin
        fs_stk_q <= 1'b1;
        if (in_pkt_q) pkt_fs_q <= 1'b1;
      end
      if (in_pkt_q && !busy && tick && !close && gap_q != '1) gap_q <= gap_q + 1'b1;
      if (close) begin
        in_pkt_q <= 1'b0; pkt_ovr_q <= 1'b0; pkt_fs_q <= 1'b0; nbytes_q <= '0;
        gap_q <= '0; lane_q <= '0; word_q <= '0;
      end
      if ((close && c_full) || (d_push && d_full) || (cnt_re_i && c_empty))
        fifo_err_q <= 1'b1;
    end
  end

  assign c_wdata = '{ovr: pkt_ovr_q, fs: pkt_fs_q, rsvd: 4'b0, bytes: nbytes_q};

  pkt_uart_fifo #(.W(32), .DEPTH(DATA_DEPTH)) i_data_fifo (
    .clk_i, .rst_ni, .clr_i(clr), .push_i(d_push), .wdata_i(d_wdata),
    .pop_i(data_re_i), .rdata_o(data_o), .full_o(d_full), .level_o(d_level)
  );

  pkt_uart_fifo #(.W(16), .DEPTH(CNT_DEPTH)) i_cnt_fifo (
    .clk_i, .rst_ni, .clr_i(clr), .push_i(close), .wdata_i(c_wdata),
    .pop_i(cnt_re_i), .rdata_o(cnt_o), .full_o(c_full), .level_o(c_level)
  );

  assign c_empty = c_level == '0;
  assign pkt_cnt = 5'(c_level);
  assign mode_o  = {10'b0, d_level != '0, pkt_cnt, gap_lim_q, in_pkt_q, mask_act,
                    1'b0, fifo_err_q, en_q, mask_en_q, ovr_stk_q, fs_stk_q};

  // R9
  clear_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |=> (c_level == '0 && d_level == '0 && !ovr_stk_q && !fs_stk_q));
  // R6
  sticky_ovr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_stk_q && !clr) |=> ovr_stk_q);
  // R5
  active_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(in_pkt_q) |-> $past(close || clr));
  // R3
  entry_nonempty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    close |-> (nbytes_q != '0 || pkt_ovr_q));
endmodule

// File: tb/test_pkt_uart_rx.sv
module test_pkt_uart_rx;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        rxd = 1'b1, tx_busy = 1'b0;
  logic        rate_we = 1'b0, mode_we = 1'b0, cnt_re = 1'b0, data_re = 1'b0;
  logic [19:0] rate = '0;
  logic [31:0] mode_w = '0, mode_rd, data_rd;
  logic [15:0] cnt_rd;

  int   errors = 0, checks = 0, bit_clks = 16, cycles = 0;
  bit   done = 1'b0;
  logic [7:0]  m_gap = '0;
  logic        m_en = 1'b0, m_mask = 1'b0;
  logic [7:0]  pkt_b[$];

  always #4 clk = ~clk;  // 125 MHz

  pkt_uart_rx i_pkt_uart_rx (
    .clk_i(clk), .rst_ni(rst_n), .rxd_i(rxd), .tx_busy_i(tx_busy),
    .rate_we_i(rate_we), .rate_i(rate), .mode_we_i(mode_we), .mode_i(mode_w),
    .mode_o(mode_rd), .cnt_re_i(cnt_re), .cnt_o(cnt_rd),
    .data_re_i(data_re), .data_o(data_rd)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-clock comparison of mode fields and mask state against the model
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      chk("R9 mode fields", {mode_rd[15:8], mode_rd[3], mode_rd[2]}, {m_gap, m_en, m_mask});
      chk("R10 mask state", mode_rd[6], m_mask & tx_busy);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic wr_mode(input logic [31:0] d);
    @(negedge clk);
    mode_w = d; mode_we = 1'b1;
    if (d != 32'h8001_0000) begin m_gap = d[15:8]; m_en = d[3]; m_mask = d[2]; end
    @(negedge clk);
    mode_we = 1'b0;
  endtask

  task automatic wr_rate(input logic [19:0] d);
    @(negedge clk);
    rate = d; rate_we = 1'b1;
    @(negedge clk);
    rate_we = 1'b0;
  endtask

  task automatic bit_out(input logic v);
    rxd = v;
    repeat (bit_clks) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b, input bit stop_ok = 1'b1);
    @(negedge clk);
    bit_out(1'b0);
    for (int i = 0; i < 8; i++) bit_out(b[i]);
    bit_out(stop_ok);
    rxd = 1'b1;
  endtask

  task automatic idle(input int nbits);
    rxd = 1'b1;
    repeat (nbits * bit_clks) @(negedge clk);
  endtask

  function automatic logic [31:0] word_of(input int k);
    logic [31:0] w = '0;
    for (int j = 0; j < 4; j++)
      if (4 * k + j < pkt_b.size()) w[j*8 +: 8] = pkt_b[4 * k + j];
    return w;
  endfunction

  task automatic read_pkt(input logic ovr, input logic fs);
    @(negedge clk);
    chk("R3 byte count", cnt_rd[9:0], pkt_b.size());
    chk("R6 R7 packet flags", {cnt_rd[15], cnt_rd[14]}, {ovr, fs});
    cnt_re = 1'b1;
    @(negedge clk);
    cnt_re = 1'b0;
    for (int k = 0; k < (pkt_b.size() + 3) / 4; k++) begin
      chk("R8 data word", data_rd, word_of(k));
      data_re = 1'b1;
      @(negedge clk);
      data_re = 1'b0;
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R4 reset readback", mode_rd, 32'h0);

    wr_rate(20'd65536);                 // 16 clocks per bit
    wr_mode(32'h0000_0200);             // gap 2, receive disabled
    send(8'h5A); idle(6);
    chk("R1 disabled no packet", mode_rd[21:16], 6'h0);

    wr_mode(32'h0000_0208);
    pkt_b = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
    send(8'h11);
    chk("R5 active mid packet", mode_rd[7], 1'b1);
    send(8'h22); send(8'h33); send(8'h44); send(8'h55);
    idle(6);
    chk("R4 packet count", mode_rd[20:16], 5'd1);
    chk("R4 data present", mode_rd[21], 1'b1);
    chk("R5 inactive after close", mode_rd[7], 1'b0);
    read_pkt(1'b0, 1'b0);
    chk("R4 data drained", mode_rd[21], 1'b0);

    send(8'hA1); send(8'hB2); send(8'hC3); idle(10);
    send(8'h01); send(8'h02); send(8'h03); send(8'h04); idle(6);
    chk("R2 two packets", mode_rd[20:16], 5'd2);
    pkt_b = '{8'hA1, 8'hB2, 8'hC3};
    read_pkt(1'b0, 1'b0);
    pkt_b = '{8'h01, 8'h02, 8'h03, 8'h04};
    read_pkt(1'b0, 1'b0);
    chk("R2 count after drain", mode_rd[20:16], 5'd0);

    send(8'h55, 1'b0); idle(1);
    send(8'hA3); idle(6);
    chk("R6 sticky overrun", mode_rd[1], 1'b1);
    pkt_b = '{8'hA3};
    read_pkt(1'b1, 1'b0);

    @(negedge clk);
    rxd = 1'b0;
    repeat (4) @(negedge clk);
    rxd = 1'b1;
    idle(4);
    chk("R7 sticky false start", mode_rd[0], 1'b1);
    chk("R7 no packet made", mode_rd[20:16], 5'd0);

    send(8'h77); idle(6);
    chk("R6 sticky kept", mode_rd[1:0], 2'b11);
    chk("R9 packet before clear", mode_rd[20:16], 5'd1);
    wr_mode(32'h8001_0000);
    chk("R9 flushed", {mode_rd[21:16], mode_rd[1:0]}, 8'h00);

    @(negedge clk);
    cnt_re = 1'b1;
    @(negedge clk);
    cnt_re = 1'b0;
    chk("R11 empty pop error", mode_rd[4], 1'b1);
    wr_mode(32'h8001_0000);
    chk("R11 error cleared", mode_rd[4], 1'b0);

    wr_mode(32'h0000_020C);
    tx_busy = 1'b1;
    send(8'h99); idle(6);
    chk("R10 masked no packet", mode_rd[21:16], 6'h0);
    tx_busy = 1'b0;
    send(8'h66); idle(6);
    pkt_b = '{8'h66};
    read_pkt(1'b0, 1'b0);

    wr_rate(20'd32768);                 // 32 clocks per bit
    bit_clks = 32;
    send(8'h3C); send(8'hC3); idle(6);
    pkt_b = '{8'h3C, 8'hC3};
    chk("R12 slower rate packet", mode_rd[20:16], 5'd1);
    read_pkt(1'b0, 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule